// File: doc/BRIEF.md
# Host Byte-to-Word Write Packer

This block is the write path from a byte-wide host port into a 64-bit memory. The host first picks a byte placement mode, then writes the target word address one byte at a time, finishing with the least significant byte. Writing that last address byte commits the address, makes the chosen placement mode active, and empties the whole write path. After that, every byte the host writes to the data register is placed into an assembly word. When a word has all eight bytes, it moves into a small queue of complete words.

The memory side sees the word at the head of the queue together with its word address and a valid flag. The word stays presented until it is acknowledged. Each acknowledged word advances the address by one. A word with fewer than eight bytes never leaves the block. Two registered status flags, full and empty, let the host pace its writes. The host detects the end of a write sequence by waiting for empty. Both flags trail the internal state by one clock.

Top module: `byte_word_gather`

## Requirements
- R1: After reset, stat_empty is 1, stat_full is 0, mem_valid is 0 and the placement mode is little-endian.
- R2: Register select codes are: 0 for the low address byte, 1 to 3 for address bytes of rising significance, 4 for data, and 5 for the placement mode (bit 0 of the written byte). Upper address bytes are only staged. Writing the low byte loads {byte3,byte2,byte1,byte0} as the word address of the next word sent.
- R3: Writing the low address byte discards the partial assembly word and every queued word. mem_valid is 0 in the following cycle.
- R4: In mode 0, the k-th byte of a word (k = 0..7) lands in bits [8k+7:8k]. In mode 1 it lands in bits [63-8k:56-8k]. A mode write takes effect only at the next low address byte write.
- R5: mem_valid rises only for a word that holds all eight bytes. A partial word is never presented.
- R6: A presented word holds mem_data and mem_addr stable until mem_ack. Each acknowledged word raises mem_addr by one. mem_ack while mem_valid is 0 has no effect.
- R7: stat_full and stat_empty show the internal condition of the previous cycle, so they change one clock after the write or acknowledge that caused the change.
- R8: Full is set when four complete words are queued and the assembly word holds eight bytes.
- R9: A data byte written while full is dropped. It never appears in any word and does not advance the byte position.
- R10: Empty is set when no complete word is queued or awaiting acknowledge. Bytes held in a partial assembly word do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select code (see R2) |
| host_wdata | input | 8 | Host write byte |
| stat_full | output | 1 | Registered full flag |
| stat_empty | output | 1 | Registered empty flag |
| mem_valid | output | 1 | A complete word is presented |
| mem_addr | output | 32 | Word address of the presented word |
| mem_data | output | 64 | Presented 64-bit word |
| mem_ack | input | 1 | Memory accepts the presented word |

## Verification
The packing path is driven in four ways. A single word with no back-pressure separates correct lane placement from shifted or reversed lanes in either mode. A partial word followed by idle cycles shows whether fewer than eight bytes can leak out. A fill against a stalled memory side, then one extra byte, exposes errors in the full threshold, the one-cycle status lag and the dropping of the excess byte. A long random mix of data writes, mode changes, address reloads and acknowledges, some arriving while nothing is valid, is compared every cycle against a queue-based model. This last pattern catches ordering, address stepping and flush-timing faults that the directed cases do not reach.

// File: rtl/bwg_pkg.sv
// Package: shared types and helpers for the byte-to-word packer.
// Assumes bytes are 8 bits wide and words are a whole number of bytes.
package bwg_pkg;

    localparam int BYTE_W = 8;

    // Byte placement mode inside an assembled word.
    typedef enum logic [0:0] {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;

endpackage

// File: rtl/bwg_host_regs.sv
// Host register decode: stages upper address bytes, holds the pending and
// active placement mode, and turns a low address byte write into a flush
// with a fully assembled load address.
// Assumes one register write per cycle and ADDR_BYTES of at least 2.
module bwg_host_regs
    import bwg_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    localparam int AW    = ADDR_BYTES * BYTE_W,
    localparam int SEL_W = $clog2(ADDR_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic              flush,
    output logic [AW-1:0]     load_addr,
    output logic              data_we,
    output byte_order_e       order_act
);
    localparam logic [SEL_W-1:0] SEL_DATA  = SEL_W'(ADDR_BYTES);
    localparam logic [SEL_W-1:0] SEL_ORDER = SEL_W'(ADDR_BYTES + 1);

    logic [AW-1:BYTE_W] stage_q;
    byte_order_e        order_pend_q;

    // Decode of the single-cycle write strobes.
    always_comb begin
        flush     = host_wr && (host_sel == '0);
        data_we   = host_wr && (host_sel == SEL_DATA);
        load_addr = {stage_q, host_wdata};
    end

    // Staging of the upper address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (host_wr) begin
            for (int k = 1; k < ADDR_BYTES; k++) begin
                if (host_sel == SEL_W'(k)) begin
                    stage_q[k*BYTE_W +: BYTE_W] <= host_wdata;
                end
            end
        end
    end

    // Pending mode written by the host; becomes active at the flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_pend_q <= ORDER_LITTLE;
            order_act    <= ORDER_LITTLE;
        end else begin
            if (host_wr && host_sel == SEL_ORDER) begin
                order_pend_q <= byte_order_e'(host_wdata[0]);
            end
            if (flush) begin
                order_act <= order_pend_q;
            end
        end
    end

    // A mode write alone must not change the active mode.
    assert_mode_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> order_act == $past(order_act));

endmodule

// File: rtl/bwg_pack.sv
// Assembly stage: places accepted bytes into one word at the lane selected
// by the active mode and offers the word to the queue once all bytes are in.
// Assumes the queue reports its own fullness and same-cycle pop.
module bwg_pack
    import bwg_pkg::*;
#(
    parameter int WORD_BYTES = 8,
    localparam int WORD_W = WORD_BYTES * BYTE_W,
    localparam int CNT_W  = $clog2(WORD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_byte,
    input  byte_order_e       order_act,
    input  logic              q_full,
    input  logic              pop,
    output logic              asm_done,
    output logic              push,
    output logic [WORD_W-1:0] asm_word
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  base;
    logic              accept;
    logic [WORD_W-1:0] word_next;
    int                lane;

    // Handshake with the queue and acceptance of the host byte.
    always_comb begin
        asm_done = (cnt_q == CNT_W'(WORD_BYTES));
        push     = asm_done && (!q_full || pop) && !flush;
        accept   = data_we && !(q_full && asm_done);
        base     = push ? '0 : cnt_q;
    end

    // Lane selection and byte insertion into the next word value.
    always_comb begin
        lane      = (order_act == ORDER_BIG) ? (WORD_BYTES - 1 - int'(base)) : int'(base);
        word_next = push ? '0 : asm_word;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (i == lane) begin
                word_next[i*BYTE_W +: BYTE_W] = data_byte;
            end
        end
    end

    // Byte counter and assembly word register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q    <= '0;
            asm_word <= '0;
        end else if (accept) begin
            cnt_q    <= base + 1'b1;
            asm_word <= word_next;
        end else if (push) begin
            cnt_q    <= '0;
            asm_word <= '0;
        end
    end

    // A byte offered while full leaves the byte position untouched.
    assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_we && q_full && asm_done && !pop && !flush |=> asm_done && $stable(asm_word));

endmodule

// File: rtl/bwg_word_queue.sv
// Queue of complete words with the memory-side presentation: the head word
// is held with its address until acknowledged; the address steps per word.
// Assumes push is only raised when a slot is free or the head leaves.
module bwg_word_queue
    import bwg_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int WORD_BYTES = 8,
    parameter int ADDR_BYTES = 4,
    localparam int WORD_W = WORD_BYTES * BYTE_W,
    localparam int AW     = ADDR_BYTES * BYTE_W,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [AW-1:0]     load_addr,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              mem_ack,
    output logic              pop,
    output logic              q_full,
    output logic              q_empty,
    output logic              mem_valid,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_data
);
    logic [WORD_W-1:0] slots_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy flags and the head presentation.
    always_comb begin
        q_empty   = (count_q == '0);
        q_full    = (count_q == CNT_W'(DEPTH));
        mem_valid = !q_empty;
        mem_data  = slots_q[rd_ptr_q];
        pop       = mem_ack && !q_empty && !flush;
    end

    // Word storage write.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            slots_q[wr_ptr_q] <= push_word;
        end
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= ptr_step(wr_ptr_q);
            if (pop)  rd_ptr_q <= ptr_step(rd_ptr_q);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Word address: loaded by the flush, advanced per acknowledged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
        end else if (flush) begin
            mem_addr <= load_addr;
        end else if (pop) begin
            mem_addr <= mem_addr + 1'b1;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!q_full || pop));

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ack && !flush |=> mem_valid && $stable(mem_data) && $stable(mem_addr));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> mem_addr == $past(mem_addr) + 1'b1);

    assert_flush_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !mem_valid);

    assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> mem_addr == $past(load_addr));

endmodule

// File: rtl/byte_word_gather.sv
// Top: byte-wide host write path packing bytes into 64-bit words for memory.
// Only complete words leave; status flags are registered one clock behind.
// Assumes the host paces itself on stat_full and waits for stat_empty.
module byte_word_gather
    import bwg_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int WORD_BYTES = 8,
    parameter int DEPTH      = 4,
    localparam int AW     = ADDR_BYTES * BYTE_W,
    localparam int WORD_W = WORD_BYTES * BYTE_W,
    localparam int SEL_W  = $clog2(ADDR_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic              stat_full,
    output logic              stat_empty,
    output logic              mem_valid,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_data,
    input  logic              mem_ack
);
    logic              flush, data_we, push, pop, q_full, q_empty, asm_done;
    logic [AW-1:0]     load_addr;
    logic [WORD_W-1:0] asm_word;
    byte_order_e       order_act;

    bwg_host_regs #(.ADDR_BYTES(ADDR_BYTES)) regs_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .flush(flush), .load_addr(load_addr),
        .data_we(data_we), .order_act(order_act)
    );

    bwg_pack #(.WORD_BYTES(WORD_BYTES)) pack_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .data_we(data_we),
        .data_byte(host_wdata), .order_act(order_act), .q_full(q_full),
        .pop(pop), .asm_done(asm_done), .push(push), .asm_word(asm_word)
    );

    bwg_word_queue #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .ADDR_BYTES(ADDR_BYTES)) queue_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .load_addr(load_addr),
        .push(push), .push_word(asm_word), .mem_ack(mem_ack), .pop(pop),
        .q_full(q_full), .q_empty(q_empty), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    // Status flags registered from the internal condition of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_full  <= 1'b0;
            stat_empty <= 1'b1;
        end else begin
            stat_full  <= q_full && asm_done;
            stat_empty <= q_empty;
        end
    end

    assert_full_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && asm_done) |=> stat_full);

    assert_not_full_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && asm_done) |=> !stat_full);

    assert_empty_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |=> stat_empty);

    assert_valid_clears_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> !stat_empty);

endmodule

// File: tb/byte_word_gather_tb_top.sv
module byte_word_gather_tb_top;
    localparam int DEPTH = 4;
    localparam logic [2:0] SEL_DATA  = 3'd4;
    localparam logic [2:0] SEL_ORDER = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic        stat_full, stat_empty, mem_valid;
    logic [31:0] mem_addr;
    logic [63:0] mem_data;
    logic        mem_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string dtag = "R4";

    always #2.5 clk = ~clk;

    byte_word_gather dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .stat_full(stat_full), .stat_empty(stat_empty),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ack(mem_ack)
    );

    // Behavioural reference model
    logic [63:0] mq[$];
    logic [63:0] m_asm;
    int          m_cnt;
    logic [31:0] m_addr;
    logic [7:0]  m_stage [4];
    bit          m_ord_p, m_ord_a, m_full, m_empty;

    always @(posedge clk) begin
        int  sz0;
        bit  full_now, pop, push, acc;
        if (!rst_n) begin
            mq.delete(); m_asm = '0; m_cnt = 0; m_addr = '0;
            foreach (m_stage[i]) m_stage[i] = '0;
            m_ord_p = 0; m_ord_a = 0; m_full = 0; m_empty = 1;
        end else begin
            sz0 = mq.size();
            full_now = (sz0 == DEPTH) && (m_cnt == 8);
            m_full = full_now;
            m_empty = (sz0 == 0);
            if (host_wr && host_sel == 3'd0) begin
                mq.delete(); m_asm = '0; m_cnt = 0;
                m_addr = {m_stage[3], m_stage[2], m_stage[1], host_wdata};
                m_ord_a = m_ord_p;
            end else begin
                pop  = (sz0 > 0) && mem_ack;
                push = (m_cnt == 8) && ((sz0 < DEPTH) || pop);
                acc  = host_wr && host_sel == SEL_DATA && !full_now;
                if (pop) begin void'(mq.pop_front()); m_addr = m_addr + 1; end
                if (push) begin mq.push_back(m_asm); m_asm = '0; m_cnt = 0; end
                if (acc) begin
                    if (m_ord_a) m_asm[8*(7-m_cnt) +: 8] = host_wdata;
                    else         m_asm[8*m_cnt +: 8] = host_wdata;
                    m_cnt++;
                end
                if (host_wr && host_sel >= 3'd1 && host_sel <= 3'd3) m_stage[host_sel] = host_wdata;
                if (host_wr && host_sel == SEL_ORDER) m_ord_p = host_wdata[0];
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit mv;
        if (!rst_n) return;
        mv = (mq.size() > 0);
        check(mem_valid == mv, "R5", "mem_valid", 64'(mem_valid), 64'(mv));
        if (mv && mem_valid) begin
            check(mem_data == mq[0], dtag, "mem_data", mem_data, mq[0]);
            check(mem_addr == m_addr, "R6", "mem_addr", 64'(mem_addr), 64'(m_addr));
        end
        check(stat_full == m_full, "R8", "stat_full", 64'(stat_full), 64'(m_full));
        check(stat_empty == m_empty, "R10", "stat_empty", 64'(stat_empty), 64'(m_empty));
    endtask

    task automatic tick(input logic we, input logic [2:0] sel, input logic [7:0] d, input logic ack);
        @(negedge clk);
        compare_all();
        host_wr = we; host_sel = sel; host_wdata = d; mem_ack = ack;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 8'h00, 1'b0);
    endtask

    task automatic set_addr(input logic [31:0] a);
        tick(1'b1, 3'd3, a[31:24], 1'b0);
        tick(1'b1, 3'd2, a[23:16], 1'b0);
        tick(1'b1, 3'd1, a[15:8], 1'b0);
        tick(1'b1, 3'd0, a[7:0], 1'b0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(stat_empty == 1'b1 && stat_full == 1'b0 && mem_valid == 1'b0, "R1",
              "reset flags", {61'd0, stat_empty, stat_full, mem_valid}, 64'h4);

        // R2 / R4: little-endian word at a loaded address
        tick(1'b1, SEL_ORDER, 8'h00, 1'b0);
        set_addr(32'h1234_5678);
        for (int i = 0; i < 8; i++) tick(1'b1, SEL_DATA, 8'h10 + 8'(i), 1'b0);
        idle(2);
        check(mem_valid && mem_data == 64'h1716_1514_1312_1110, "R4", "little word",
              mem_data, 64'h1716_1514_1312_1110);
        check(mem_addr == 32'h1234_5678, "R2", "loaded address", 64'(mem_addr), 64'h1234_5678);
        tick(1'b0, 3'd0, 8'h00, 1'b1);
        idle(2);
        check(mem_addr == 32'h1234_5679, "R6", "address step", 64'(mem_addr), 64'h1234_5679);

        // R5 / R10: partial word never leaves, empty stays set
        for (int i = 0; i < 5; i++) tick(1'b1, SEL_DATA, 8'hA0 + 8'(i), 1'b0);
        idle(4);
        check(!mem_valid, "R5", "partial not sent", 64'(mem_valid), 64'd0);
        check(stat_empty, "R10", "empty with partial", 64'(stat_empty), 64'd1);

        // R4: mode write deferred; R3: flush drops the partial word
        tick(1'b1, SEL_ORDER, 8'h01, 1'b0);
        for (int i = 0; i < 3; i++) tick(1'b1, SEL_DATA, 8'hB0 + 8'(i), 1'b0);
        set_addr(32'h0000_0100);
        for (int i = 0; i < 8; i++) tick(1'b1, SEL_DATA, 8'h20 + 8'(i), 1'b0);
        idle(2);
        check(mem_valid && mem_data == 64'h2021_2223_2425_2627, "R3", "flushed partial gone",
              mem_data, 64'h2021_2223_2425_2627);
        check(mem_addr == 32'h0000_0100, "R2", "reloaded address", 64'(mem_addr), 64'h100);
        tick(1'b0, 3'd0, 8'h00, 1'b1);
        idle(1);

        // R7 / R8: fill against a stalled memory side
        for (int i = 0; i < 40; i++) tick(1'b1, SEL_DATA, 8'(i), 1'b0);
        idle(1);
        check(!stat_full, "R7", "full lags one clock", 64'(stat_full), 64'd0);
        idle(1);
        check(stat_full, "R8", "full at threshold", 64'(stat_full), 64'd1);

        // R9: excess byte dropped
        dtag = "R9";
        tick(1'b1, SEL_DATA, 8'hEE, 1'b0);
        for (int i = 0; i < 8; i++) tick(1'b1, SEL_DATA, 8'h60 + 8'(i), 1'b1);
        for (int i = 0; i < 12; i++) tick(1'b0, 3'd0, 8'h00, 1'b1);
        idle(2);
        check(stat_empty, "R10", "drained empty", 64'(stat_empty), 64'd1);
        dtag = "R4";

        // R3: flush while words are queued
        for (int i = 0; i < 16; i++) tick(1'b1, SEL_DATA, 8'h80 + 8'(i), 1'b0);
        idle(1);
        tick(1'b1, 3'd0, 8'h40, 1'b1);
        idle(1);
        check(!mem_valid, "R3", "flush clears queue", 64'(mem_valid), 64'd0);
        idle(2);
        check(stat_empty, "R3", "empty after flush", 64'(stat_empty), 64'd1);

        // R6: acknowledge with nothing valid has no effect
        tick(1'b0, 3'd0, 8'h00, 1'b1);
        tick(1'b0, 3'd0, 8'h00, 1'b1);
        idle(1);
        check(mem_addr == 32'h0000_0140, "R6", "idle ack ignored", 64'(mem_addr), 64'h140);

        // Random mix compared every cycle against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] s;
            r = int'($urandom_range(0, 99));
            if (r < 60) s = SEL_DATA;
            else if (r < 64) s = SEL_ORDER;
            else if (r < 66) s = 3'd0;
            else if (r < 70) s = 3'(1 + $urandom_range(0, 2));
            else s = SEL_DATA;
            tick(r < 85, s, 8'($urandom), ($urandom_range(0, 3) != 0));
        end
        idle(20);
        finish_run();
    end
endmodule